// File: doc/BRIEF.md
# Skewed Pipelined Ripple Adder/Subtractor

This block adds or subtracts two WIDTH-bit operands with a ripple carry that is registered at every bit position. Stage i holds the full-adder cell for bit i only, so the carry moves up by one bit per clock tick. Each tick stands for one phase of a four-phase supply clock. Operand bits are held back by delay lines whose depth equals their bit index, so each bit reaches its cell in the same tick as the carry from the bit below. Sum bits then pass through deskew lines of depth WIDTH-1-i, so every bit of a result leaves at the same time.

A new operand pair with its own add/subtract select can enter on every tick. The select travels down the skew lines with the operand bits. For subtraction the cell at each position inverts its subtrahend bit, and the carry into bit 0 is forced to one. A parameter chooses whether the data registers take the reset or only the valid line does.

Top module: `addsub_skew_top`

## Requirements
- R1: With op_sub=0, sum_out equals (a_in + b_in) mod 2^WIDTH and carry_out equals bit WIDTH of the full sum.
- R2: With op_sub=1, sum_out equals (a_in - b_in) mod 2^WIDTH and carry_out is 1 when a_in >= b_in (unsigned, no borrow) and 0 when a borrow occurs.
- R3: A pair presented with in_valid=1 at a rising edge produces its result with out_valid=1 exactly WIDTH rising edges later, counting that edge as the first.
- R4: The select is bound to its own operand pair, so add and subtract requests may alternate on consecutive ticks and each result follows its own select.
- R5: The block accepts one pair per tick with no stall, and results of back-to-back inputs appear on consecutive ticks.
- R6: out_valid reproduces the in_valid pattern, gaps included, delayed by WIDTH ticks. It is never high when no pair is in flight.
- R7: While rst_n is low and until the first valid result, out_valid is 0. With RESET_DATA=1, sum_out and carry_out are 0 as well.
- R8: Wraparound at full width: all-ones plus one gives zero with carry_out=1, and zero minus one gives all-ones with carry_out=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per supply phase |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present this tick |
| op_sub | input | 1 | 1 = subtract b_in from a_in, 0 = add |
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand (subtrahend when op_sub=1) |
| out_valid | output | 1 | Aligned result present |
| sum_out | output | WIDTH | Sum or difference, modulo 2^WIDTH |
| carry_out | output | 1 | Carry from the top bit; for subtraction, 1 = no borrow |

## Verification
The bench builds the block with WIDTH=8 and RESET_DATA=1. At this width every skew depth from 0 to 7 and every deskew depth is exercised, and the all-ones and zero operand corners can be reached directly. Because the data registers take the reset, the zero reset state of the result outputs can be checked at the ports. Streams of alternating selects, unbroken runs and gapped traffic are all compared against unsigned reference sums and differences, and each result's arrival is checked against its issue tick.

// File: rtl/addsub_skew_pkg.sv
package addsub_skew_pkg;

   typedef struct packed {
      logic carry;
      logic sum;
   } bit_result_t;

   function automatic bit_result_t full_add(input logic x, input logic y, input logic ci);
      bit_result_t r;
      r.sum   = x ^ y ^ ci;
      r.carry = (x & y) | (ci & (x ^ y));
      return r;
   endfunction

endpackage

// File: rtl/addsub_skew_delay.sv
module addsub_skew_delay #(
   parameter int W          = 1,
   parameter int DEPTH      = 0,
   parameter bit RESET_DATA = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("addsub_skew_delay: W must be at least 1");
   end
   if (DEPTH < 0) begin : g_bad_depth
      $error("addsub_skew_delay: DEPTH must not be negative");
   end

   if (DEPTH == 0) begin : g_wire
      wire unused_pins = clk ^ rst_n;
      assign q = d;
   end else begin : g_regs
      logic [W-1:0] pipe [DEPTH];

      if (RESET_DATA) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int j = 0; j < DEPTH; j++) pipe[j] <= '0;
            end else begin
               pipe[0] <= d;
               for (int j = 1; j < DEPTH; j++) pipe[j] <= pipe[j-1];
            end
         end
      end else begin : g_norst
         wire unused_rst = rst_n;
         always_ff @(posedge clk) begin
            pipe[0] <= d;
            for (int j = 1; j < DEPTH; j++) pipe[j] <= pipe[j-1];
         end
      end

      assign q = pipe[DEPTH-1];
   end

endmodule

// File: rtl/addsub_skew_cell.sv
module addsub_skew_cell
   import addsub_skew_pkg::*;
#(
   parameter bit RESET_DATA = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic x,
   input  logic y,
   input  logic invert_y,
   input  logic ci,
   output logic sum,
   output logic carry
);

   bit_result_t nxt;
   bit_result_t held;

   assign nxt = full_add(x, y ^ invert_y, ci);

   if (RESET_DATA) begin : g_rst
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) held <= '0;
         else        held <= nxt;
      end
   end else begin : g_norst
      always_ff @(posedge clk) held <= nxt;
   end

   assign sum   = held.sum;
   assign carry = held.carry;

   // R1/R2: equal effective inputs generate or kill the carry regardless of ci
   p_gen_kill_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (x == (y ^ invert_y)) |=> (carry == $past(x)));

   // R1/R2: differing effective inputs pass ci up and flip it into the sum
   p_propagate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (x != (y ^ invert_y)) |=> (carry == $past(ci) && sum == !$past(ci)));

endmodule

// File: rtl/addsub_skew_top.sv
module addsub_skew_top #(
   parameter int WIDTH      = 8,
   parameter bit RESET_DATA = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             op_sub,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   output logic             out_valid,
   output logic [WIDTH-1:0] sum_out,
   output logic             carry_out
);

   localparam int LATENCY = WIDTH;
   localparam int OCC_W   = $clog2(LATENCY + 2);

   if (WIDTH < 1) begin : g_bad_width
      $error("addsub_skew_top: WIDTH must be at least 1");
   end

   logic [WIDTH:0]   carry_chain;
   logic [WIDTH-1:0] sum_raw;
   logic [WIDTH-1:0] sum_aligned;

   // the carry into bit 0 is the select itself: one for subtract
   assign carry_chain[0] = op_sub;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [2:0] skewed;

      // select, operand-a bit and operand-b bit wait i ticks for the carry
      addsub_skew_delay #(.W(3), .DEPTH(i), .RESET_DATA(RESET_DATA)) u_skew (
         .clk (clk),
         .rst_n (rst_n),
         .d   ({op_sub, a_in[i], b_in[i]}),
         .q   (skewed)
      );

      addsub_skew_cell #(.RESET_DATA(RESET_DATA)) u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .x        (skewed[1]),
         .y        (skewed[0]),
         .invert_y (skewed[2]),
         .ci       (carry_chain[i]),
         .sum      (sum_raw[i]),
         .carry    (carry_chain[i+1])
      );

      // lower bits wait for the top bit so the word leaves aligned
      addsub_skew_delay #(.W(1), .DEPTH(WIDTH-1-i), .RESET_DATA(RESET_DATA)) u_deskew (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (sum_raw[i]),
         .q     (sum_aligned[i])
      );
   end

   addsub_skew_delay #(.W(1), .DEPTH(LATENCY), .RESET_DATA(1'b1)) u_valid (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (in_valid),
      .q     (out_valid)
   );

   assign sum_out   = sum_aligned;
   assign carry_out = carry_chain[WIDTH];

   // in-flight count used by the checks below
   logic [OCC_W-1:0] occ;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) occ <= '0;
      else begin
         case ({in_valid, out_valid})
            2'b10:   occ <= occ + 1'b1;
            2'b01:   occ <= occ - 1'b1;
            default: occ <= occ;
         endcase
      end
   end

   p_occ_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= OCC_W'(LATENCY));

   p_no_phantom_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (occ != '0));

   // subtracting equal low bits: 1 + a0 + ~a0 leaves sum 0 with carry 1
   p_stage0_sub_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sub && a_in[0] == b_in[0]) |=> (carry_chain[1] && !sum_raw[0]));

   // adding two zero low bits can produce no carry
   p_stage0_add_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_sub && !a_in[0] && !b_in[0]) |=> (!carry_chain[1] && !sum_raw[0]));

endmodule

// File: tb/addsub_skew_top_tb_top.sv
`timescale 1ns/1ps
module addsub_skew_top_tb_top;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         op_sub = 1'b0;
   logic [W-1:0] a_in = '0;
   logic [W-1:0] b_in = '0;
   logic         out_valid;
   logic [W-1:0] sum_out;
   logic         carry_out;

   always #2.5 clk = ~clk;

   addsub_skew_top #(.WIDTH(W), .RESET_DATA(1'b1)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .op_sub    (op_sub),
      .a_in      (a_in),
      .b_in      (b_in),
      .out_valid (out_valid),
      .sum_out   (sum_out),
      .carry_out (carry_out)
   );

   int cyc = 0;
   int n_cmp = 0;
   int n_bad = 0;
   logic [W-1:0] exp_sum_q [$];
   logic         exp_c_q   [$];
   int           issue_q   [$];
   int           tag_q     [$];

   always @(posedge clk) cyc++;

   function automatic string tag_name(input int t);
      case (t)
         1: return "R1";
         2: return "R2";
         3: return "R3";
         4: return "R4";
         5: return "R5";
         6: return "R6";
         7: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic send(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic sub, input int tag);
      logic [W:0] full;
      @(negedge clk);
      in_valid = 1'b1;
      op_sub   = sub;
      a_in     = a;
      b_in     = b;
      if (sub) begin
         exp_sum_q.push_back(a - b);
         exp_c_q.push_back(a >= b);
      end else begin
         full = {1'b0, a} + {1'b0, b};
         exp_sum_q.push_back(full[W-1:0]);
         exp_c_q.push_back(full[W]);
      end
      issue_q.push_back(cyc);
      tag_q.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b0;
         a_in = $urandom;
         b_in = $urandom;
         op_sub = $urandom;
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         n_cmp++;
         if (exp_sum_q.size() == 0) begin
            n_bad++;
            $display("FAIL R6: out_valid=1 with nothing in flight (expected 0)");
         end else begin
            logic [W-1:0] es;
            logic         ec;
            int           iss;
            int           tg;
            es  = exp_sum_q.pop_front();
            ec  = exp_c_q.pop_front();
            iss = issue_q.pop_front();
            tg  = tag_q.pop_front();
            if (sum_out !== es || carry_out !== ec) begin
               n_bad++;
               $display("FAIL %s: sum=%h carry=%b expected sum=%h carry=%b",
                        tag_name(tg), sum_out, carry_out, es, ec);
            end
            n_cmp++;
            // R3: arrival tick counted from issue
            if (cyc - iss != W) begin
               n_bad++;
               $display("FAIL R3: latency=%0d expected=%0d", cyc - iss, W);
            end
         end
      end
   end

   task automatic finish_run;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete (expected completion)");
      finish_run();
   end

   initial begin
      // R7: reset state
      repeat (3) @(negedge clk);
      n_cmp++;
      if (out_valid !== 1'b0 || sum_out !== '0 || carry_out !== 1'b0) begin
         n_bad++;
         $display("FAIL R7: during reset valid=%b sum=%h carry=%b expected 0/00/0",
                  out_valid, sum_out, carry_out);
      end
      rst_n = 1'b1;
      idle(2);
      n_cmp++;
      if (out_valid !== 1'b0 || sum_out !== '0 || carry_out !== 1'b0) begin
         n_bad++;
         $display("FAIL R7: after reset valid=%b sum=%h carry=%b expected 0/00/0",
                  out_valid, sum_out, carry_out);
      end

      // R1: additions
      send(8'h03, 8'h05, 1'b0, 1);
      send(8'h55, 8'hAA, 1'b0, 1);
      send(8'h80, 8'h80, 1'b0, 1);
      send(8'h7F, 8'h01, 1'b0, 1);
      // R8: wraparound
      send(8'hFF, 8'h01, 1'b0, 8);
      send(8'h00, 8'h01, 1'b1, 8);
      send(8'hFF, 8'hFF, 1'b0, 8);
      send(8'h00, 8'hFF, 1'b1, 8);
      // R2: subtractions
      send(8'h0A, 8'h03, 1'b1, 2);
      send(8'h03, 8'h0A, 1'b1, 2);
      send(8'h80, 8'h01, 1'b1, 2);
      send(8'h5C, 8'h5C, 1'b1, 2);
      send(8'h00, 8'h00, 1'b1, 2);
      idle(W + 2);

      // R4: select alternates every tick
      for (int k = 0; k < 24; k++) send(W'($urandom), W'($urandom), k[0], 4);
      // R5: unbroken run of mixed operations
      for (int k = 0; k < 64; k++) send(W'($urandom), W'($urandom), 1'($urandom), 5);
      // R6: gapped traffic
      for (int k = 0; k < 20; k++) begin
         send(W'($urandom), W'($urandom), 1'($urandom), 6);
         idle(k % 4);
      end
      idle(W + 4);

      // R6: everything sent has come back
      n_cmp++;
      if (exp_sum_q.size() != 0) begin
         n_bad++;
         $display("FAIL R6: %0d results outstanding expected 0", exp_sum_q.size());
      end
      finish_run();
   end

endmodule